// File: doc/BRIEF.md
# Dual-Channel Compare Output Waveform Unit

This block turns the state of an external up/down counter into two output waveforms, channel A and channel B. On every counter tick it compares the count with each channel's buffered compare value. It also looks at the TOP and BOTTOM strobes and the counting direction. From these it sets, clears or toggles one output flip-flop per channel. What each 2-bit output-mode code does depends on the 3-bit waveform mode:
- In the non-PWM modes it toggles, clears or sets the flip-flop on a match.
- In fast PWM it gives inverting or non-inverting pulses that restart at BOTTOM.
- In phase-correct PWM the action depends on the counting direction.

For each channel the unit also produces a pin-override enable and a pad-drive enable. The pad-drive enable is the override qualified by that channel's data-direction bit. The counter, the compare buffering and any forced-compare logic are outside this block. The block only reacts to the values they present.

Waveform mode encoding:

| Code | Mode |
|---|---|
| 0 | Normal (non-PWM) |
| 2 | CTC (non-PWM) |
| 1, 5 | Phase-correct PWM |
| 3, 7 | Fast PWM |
| 4, 6 | Behave as non-PWM |

Top module: `cwu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both waveform flip-flops become 0.
- R2: A channel's override is 1 exactly when its output mode is connected. A mode is connected when it is nonzero and is not a disconnected 01 case (R7, R8). The drive output equals override AND that channel's direction bit.
- R3: While a channel is disconnected, its waveform keeps its value.
- R4: In non-PWM modes (waveform-mode bit 0 is 0), a match changes the output as follows: output mode 01 toggles it, 10 clears it and 11 sets it.
- R5: In fast PWM (waveform-mode bits 1:0 = 11), a match with output mode 10 clears the output and a tick with BOTTOM set sets it. Output mode 11 does the opposite: a match sets the output and BOTTOM clears it.
- R6: In phase-correct PWM (waveform-mode bits 1:0 = 01), output mode 10 clears the output on a match when `count_up`=1 and sets it on a match when `count_up`=0. Output mode 11 does the reverse.
- R7: In either PWM family, channel A with output mode 01 toggles on a match when waveform-mode bit 2 is 1. When bit 2 is 0, the channel is disconnected.
- R8: In either PWM family, channel B with output mode 01 is disconnected.
- R9: In a PWM mode, when a channel's compare value equals `top_val` and output-mode bit 1 is set, the match is ignored.
  - In fast PWM the normal BOTTOM action still applies.
  - In phase-correct PWM, a tick with `at_top` set applies the down-counting action: set for 10, clear for 11.
- R10: A match is taken only on a cycle with `tick`=1 and count equal to the compare value. Without a tick the outputs do not change.
- R11: In fast PWM, when a match and BOTTOM fall on the same tick, the BOTTOM action wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter advanced this cycle |
| count | input | W | Current count |
| count_up | input | 1 | 1 while counting up |
| at_top | input | 1 | Count is at TOP |
| at_bottom | input | 1 | Count is at BOTTOM |
| top_val | input | W | Current TOP value |
| cmp_a | input | W | Buffered compare value, channel A |
| cmp_b | input | W | Buffered compare value, channel B |
| wave_mode | input | 3 | Waveform mode |
| omode_a | input | 2 | Output mode, channel A |
| omode_b | input | 2 | Output mode, channel B |
| dir_a | input | 1 | Data-direction bit, channel A |
| dir_b | input | 1 | Data-direction bit, channel B |
| wave_a | output | 1 | Waveform, channel A |
| wave_b | output | 1 | Waveform, channel B |
| ovr_a | output | 1 | Pin override, channel A |
| ovr_b | output | 1 | Pin override, channel B |
| drv_a | output | 1 | Pad drive enable, channel A |
| drv_b | output | 1 | Pad drive enable, channel B |

## Verification
The bench sweeps the waveform modes 0 to 5 and 7, every output-mode code, both directions and both starting output levels. Each combination is tried against seven events:
- a held count equal to the compare value with no tick;
- a mid-range match;
- BOTTOM without a match;
- TOP without a match;
- a match at TOP;
- a match at BOTTOM;
- BOTTOM with the compare value at TOP.

The held count shows that a match needs a tick. The up and down runs separate the phase-correct actions. The two starting levels tell a toggle from a set or a clear. Running both channels under the same codes, with opposite direction bits, exposes the channel-specific handling of code 01 and the drive gating.

// File: rtl/cwu_pkg.sv
// Shared types for the compare waveform unit.
package cwu_pkg;

    // Counting family selected by the waveform mode.
    typedef enum logic [1:0] {
        FAM_PLAIN = 2'd0,
        FAM_FAST  = 2'd1,
        FAM_PHASE = 2'd2
    } wave_fam_t;

    // Action applied to a channel's output flip-flop.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } wave_act_t;

endpackage

// File: rtl/cwu_mode_decode.sv
// Maps the 3-bit waveform mode onto a counting family.
// Assumes: bit 0 clear means non-PWM (codes 4 and 6 fall here too);
// low bits 11 mean fast PWM and 01 mean phase-correct PWM.
module cwu_mode_decode
    import cwu_pkg::*;
(
    input  logic [2:0] wave_mode,
    output wave_fam_t  fam
);

    // Decode the counting family from the low mode bits.
    always_comb begin
        if (!wave_mode[0])      fam = FAM_PLAIN;
        else if (wave_mode[1])  fam = FAM_FAST;
        else                    fam = FAM_PHASE;
    end

endmodule

// File: rtl/cwu_channel.sv
// One compare output channel: decides the action for this tick and holds
// the output flip-flop. TOGGLE_IN_PWM selects whether output mode 01 may
// toggle in PWM modes (when waveform-mode bit 2 is set) or is disconnected.
// Assumes: strobes and count are valid in the cycle tick is high.
module cwu_channel
    import cwu_pkg::*;
#(
    parameter int W             = 8,
    parameter bit TOGGLE_IN_PWM = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic         count_up,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [W-1:0] top_val,
    input  logic [W-1:0] cmp_val,
    input  logic [2:0]   wave_mode,
    input  wave_fam_t    fam,
    input  logic [1:0]   omode,
    input  logic         dir,
    output logic         wave,
    output logic         ovr,
    output logic         drv
);

    logic      toggle_ok;
    logic      top_hit;
    logic      match;
    wave_act_t act;

    // Work out whether code 01 is a live toggle in the current family.
    always_comb begin
        if (fam == FAM_PLAIN) toggle_ok = 1'b1;
        else                  toggle_ok = TOGGLE_IN_PWM && wave_mode[2];
    end

    // Connection status drives the override and the gated pad enable.
    always_comb begin
        ovr = (omode != 2'b00) && !((omode == 2'b01) && !toggle_ok);
        drv = ovr && dir;
    end

    // Compare-at-TOP special case and the qualified match event.
    always_comb begin
        top_hit = (fam != FAM_PLAIN) && omode[1] && (cmp_val == top_val);
        match   = tick && (count == cmp_val) && !top_hit;
    end

    // Pick the action for this cycle from family, output mode and events.
    always_comb begin
        act = ACT_HOLD;
        if (ovr && tick) begin
            unique case (fam)
                FAM_FAST: begin
                    if (at_bottom && omode[1])
                        act = omode[0] ? ACT_CLR : ACT_SET;
                    else if (match)
                        act = (omode == 2'b01) ? ACT_TGL :
                              (omode[0] ? ACT_SET : ACT_CLR);
                end
                FAM_PHASE: begin
                    if (top_hit && at_top)
                        act = omode[0] ? ACT_CLR : ACT_SET;
                    else if (match) begin
                        if (omode == 2'b01)
                            act = ACT_TGL;
                        else if (omode[0] ^ count_up)
                            act = ACT_CLR;
                        else
                            act = ACT_SET;
                    end
                end
                default: begin
                    if (match)
                        act = (omode == 2'b01) ? ACT_TGL :
                              (omode[0] ? ACT_SET : ACT_CLR);
                end
            endcase
        end
    end

    // Output flip-flop: synchronous reset, then apply the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else begin
            unique case (act)
                ACT_SET: wave <= 1'b1;
                ACT_CLR: wave <= 1'b0;
                ACT_TGL: wave <= ~wave;
                default: wave <= wave;
            endcase
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !wave);

    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !ovr |=> $stable(wave));

    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !tick |=> $stable(wave));

    a_r2_drive_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> !drv);

    a_r4_plain_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && tick && fam == FAM_PLAIN && omode == 2'b11
        && count == cmp_val |=> wave);

    a_r5_fast_bottom_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && tick && at_bottom && fam == FAM_FAST && omode == 2'b10 |=> wave);

    a_r11_bottom_beats_match: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && tick && at_bottom && fam == FAM_FAST && omode == 2'b11
        && count == cmp_val |=> !wave);

endmodule

// File: rtl/cwu_top.sv
// Dual-channel compare output waveform unit. Channel A (index 0) allows
// the PWM toggle on code 01; channel B (index 1) treats it as reserved.
// Assumes: an external counter supplies count, direction and boundary strobes.
module cwu_top
    import cwu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic         count_up,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [W-1:0] top_val,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic [2:0]   wave_mode,
    input  logic [1:0]   omode_a,
    input  logic [1:0]   omode_b,
    input  logic         dir_a,
    input  logic         dir_b,
    output logic         wave_a,
    output logic         wave_b,
    output logic         ovr_a,
    output logic         ovr_b,
    output logic         drv_a,
    output logic         drv_b
);

    localparam int NCH = 2;

    wave_fam_t      fam;
    logic [W-1:0]   cmp_v  [NCH];
    logic [1:0]     mode_v [NCH];
    logic [NCH-1:0] dir_v, wave_v, ovr_v, drv_v;

    // Gather per-channel inputs into arrays for the generate loop.
    always_comb begin
        cmp_v[0]  = cmp_a;
        cmp_v[1]  = cmp_b;
        mode_v[0] = omode_a;
        mode_v[1] = omode_b;
        dir_v     = {dir_b, dir_a};
    end

    cwu_mode_decode u_dec (
        .wave_mode (wave_mode),
        .fam       (fam)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cwu_channel #(
            .W             (W),
            .TOGGLE_IN_PWM (i == 0)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .count     (count),
            .count_up  (count_up),
            .at_top    (at_top),
            .at_bottom (at_bottom),
            .top_val   (top_val),
            .cmp_val   (cmp_v[i]),
            .wave_mode (wave_mode),
            .fam       (fam),
            .omode     (mode_v[i]),
            .dir       (dir_v[i]),
            .wave      (wave_v[i]),
            .ovr       (ovr_v[i]),
            .drv       (drv_v[i])
        );
    end

    // Route the channel results to the named ports.
    always_comb begin
        wave_a = wave_v[0];
        wave_b = wave_v[1];
        ovr_a  = ovr_v[0];
        ovr_b  = ovr_v[1];
        drv_a  = drv_v[0];
        drv_b  = drv_v[1];
    end

    a_r8_b_reserved_off: assert property (@(posedge clk) disable iff (!rst_n)
        wave_mode[0] && omode_b == 2'b01 |-> !ovr_b);

endmodule

// File: tb/cwu_top_test.sv
// Sweep bench for cwu_top: every mode / code / direction / level / event.
module cwu_top_test;

    localparam int W    = 8;
    localparam int TOPV = 200;
    localparam int MID  = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0, count_up = 1'b1, at_top = 1'b0, at_bottom = 1'b0;
    logic [W-1:0] count = '0, top_val = TOPV[W-1:0], cmp_a = '0, cmp_b = '0;
    logic [2:0]   wave_mode = 3'd0;
    logic [1:0]   omode_a = 2'b11, omode_b = 2'b11;
    logic         dir_a = 1'b1, dir_b = 1'b0;
    logic         wave_a, wave_b, ovr_a, ovr_b, drv_a, drv_b;

    int checks = 0;
    int errors = 0;

    cwu_top #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
        .count_up(count_up), .at_top(at_top), .at_bottom(at_bottom),
        .top_val(top_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .wave_mode(wave_mode), .omode_a(omode_a), .omode_b(omode_b),
        .dir_a(dir_a), .dir_b(dir_b), .wave_a(wave_a), .wave_b(wave_b),
        .ovr_a(ovr_a), .ovr_b(ovr_b), .drv_a(drv_a), .drv_b(drv_b)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Connection per R2/R7/R8.
    function automatic logic conn_of(input bit is_a, input logic [2:0] wm,
                                     input logic [1:0] om);
        if (om == 2'b00) return 1'b0;
        if (om == 2'b01 && wm[0]) return is_a && wm[2];
        return 1'b1;
    endfunction

    // Next output level per R4..R11.
    function automatic logic next_of(input bit is_a, input logic [2:0] wm,
            input logic [1:0] om, input logic q, input logic tk, input int cnt,
            input logic up, input logic atp, input logic abt, input int cmp);
        logic hit, m;
        if (!conn_of(is_a, wm, om) || !tk) return q;
        hit = wm[0] && om[1] && (cmp == TOPV);
        m   = (cnt == cmp) && !hit;
        if (wm[1:0] == 2'b11 && abt && om[1]) return (om == 2'b10);
        if (wm[1:0] == 2'b01 && hit && atp)   return (om == 2'b10);
        if (!m) return q;
        if (om == 2'b01) return ~q;
        if (wm[1:0] == 2'b01) return (om == 2'b11) ? up : ~up;
        return (om == 2'b11);
    endfunction

    function automatic string tag_of(input bit is_a, input logic [2:0] wm,
                                     input logic [1:0] om, input int ev);
        if (ev == 0) return "R10";
        if (om == 2'b00) return "R3";
        if (om == 2'b01 && wm[0]) return is_a ? "R7" : "R8";
        if (wm[0] && om[1] && (ev == 4 || ev == 6)) return "R9";
        if (wm[1:0] == 2'b11 && ev == 5) return "R11";
        if (!wm[0]) return "R4";
        if (wm[1]) return "R5";
        return "R6";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int wms [7] = '{0, 1, 2, 3, 4, 5, 7};
        // Reset while a set-on-match is presented: R1.
        tick = 1'b1; count = MID; cmp_a = MID; cmp_b = MID;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "wave_a in reset", wave_a, 1'b0);
        check("R1", "wave_b in reset", wave_b, 1'b0);
        rst_n = 1'b1;

        for (int wi = 0; wi < 7; wi++)
        for (int om = 0; om < 4; om++)
        for (int up = 0; up < 2; up++)
        for (int pv = 0; pv < 2; pv++)
        for (int ev = 0; ev < 7; ev++) begin
            int cnt, cmp;
            logic tk, atp, abt, ea, eb;
            // Preload both outputs to pv with a non-PWM set/clear match.
            @(negedge clk);
            wave_mode = 3'd0; omode_a = pv ? 2'b11 : 2'b10; omode_b = omode_a;
            tick = 1'b1; count = MID; cmp_a = MID; cmp_b = MID;
            at_top = 1'b0; at_bottom = 1'b0;
            @(negedge clk);
            tk = 1'b1; atp = 1'b0; abt = 1'b0; cnt = MID; cmp = MID;
            case (ev)
                0: tk = 1'b0;
                1: ;
                2: begin cnt = 0; abt = 1'b1; end
                3: begin cnt = TOPV; atp = 1'b1; end
                4: begin cnt = TOPV; cmp = TOPV; atp = 1'b1; end
                5: begin cnt = 0; cmp = 0; abt = 1'b1; end
                default: begin cnt = 0; cmp = TOPV; abt = 1'b1; end
            endcase
            wave_mode = wms[wi][2:0]; omode_a = om[1:0]; omode_b = om[1:0];
            count_up = up[0]; tick = tk; at_top = atp; at_bottom = abt;
            count = cnt[W-1:0]; cmp_a = cmp[W-1:0]; cmp_b = cmp[W-1:0];
            dir_a = ev[0]; dir_b = ~ev[0];
            ea = next_of(1'b1, wave_mode, omode_a, pv[0], tk, cnt, up[0], atp, abt, cmp);
            eb = next_of(1'b0, wave_mode, omode_b, pv[0], tk, cnt, up[0], atp, abt, cmp);
            #1;
            check("R2", "ovr_a", ovr_a, conn_of(1'b1, wave_mode, omode_a));
            check("R2", "ovr_b", ovr_b, conn_of(1'b0, wave_mode, omode_b));
            check("R2", "drv_a", drv_a, conn_of(1'b1, wave_mode, omode_a) & dir_a);
            check("R2", "drv_b", drv_b, conn_of(1'b0, wave_mode, omode_b) & dir_b);
            @(negedge clk);
            check(tag_of(1'b1, wave_mode, omode_a, ev), "wave_a", wave_a, ea);
            check(tag_of(1'b0, wave_mode, omode_b, ev), "wave_b", wave_b, eb);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule